// File: doc/BRIEF.md
# Light-Load Burst Gating Controller

This block decides, cycle by cycle, whether a switching regulator may fire gate pulses while the load is light. Two digitized comparator flags describe the feedback level: one is set while feedback sits under the lower burst threshold, the other while feedback sits over the upper burst threshold. The gap between the two thresholds gives the gating its hysteresis. A third flag tells whether feedback is above the level where frequency foldback ends. A strobe marks each switching cycle boundary.

When feedback stays under the lower threshold without a break for a programmed dwell, the controller moves into a deep low-power state and signals the supply to reduce its bias current. When feedback then climbs over the upper threshold, it runs a timed wake sequence before it re-enables switching. It also picks one of three peak-current floor levels from the load region. That choice changes only at a cycle boundary.

States: `ST_RUN` (switching allowed), `ST_HALT` (burst stop, switching off), `ST_DEEP` (deep low-power), `ST_WAKE` (timed wake/reset). Transitions: RUN→HALT when the low flag is set; HALT→RUN when the high flag is set; HALT→DEEP when the low flag has been set for `ENTRY_TICKS` consecutive cycles; DEEP→WAKE when the high flag is set; WAKE→RUN after `WAKE_TICKS` cycles. The reset is synchronous and active high.

Top module: `burst_gate_ctrl`

## Requirements
- R1: While `rst` is sampled high and on the first cycle after it, `sw_en`=1, `deep_lp`=0, `wake_rst`=0 and `floor_sel`=2'b00.
- R2: In RUN, a clock edge that samples `fb_lo_flag`=1 drives `sw_en` to 0 in the following cycle.
- R3: In HALT, switching stays off while `fb_hi_flag`=0, whatever the value of `fb_lo_flag`. An edge that samples `fb_hi_flag`=1 sets `sw_en` to 1 in the next cycle.
- R4: `deep_lp` rises after the edge at which `fb_lo_flag` has been sampled high on `ENTRY_TICKS` consecutive edges, provided the block is in HALT.
- R5: A single edge that samples `fb_lo_flag`=0 restarts the dwell count from zero.
- R6: In DEEP, an edge that samples `fb_hi_flag`=1 clears `deep_lp`, keeps `sw_en` low and holds `wake_rst` high for exactly `WAKE_TICKS` cycles. After those cycles `sw_en` returns to 1.
- R7: In DEEP, `fb_lo_flag` has no effect. The block leaves DEEP only on `fb_hi_flag`.
- R8: `floor_sel` encodes the floor as 2'b00 = high (`fb_hi_flag`=1 and `fb_blank_flag`=1), 2'b01 = middle (`fb_hi_flag`=1 and `fb_blank_flag`=0), and 2'b10 = low. The value 2'b11 never appears.
- R9: `floor_sel` takes a new value only after an edge that samples `cyc_strobe`=1. Without a strobe, flag changes leave it unchanged.
- R10: A strobe taken while `fb_hi_flag`=0 selects the low floor 2'b10, whatever `fb_blank_flag` is.
- R11: `sw_en` and `deep_lp` are never high together, and `sw_en` is never high during `wake_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_lo_flag | input | 1 | Feedback below lower burst threshold |
| fb_hi_flag | input | 1 | Feedback above upper burst threshold |
| fb_blank_flag | input | 1 | Feedback above foldback-end level |
| cyc_strobe | input | 1 | Switching cycle boundary strobe |
| sw_en | output | 1 | Gate pulses permitted |
| deep_lp | output | 1 | Deep low-power supply request |
| floor_sel | output | 2 | Peak-current floor code |
| wake_rst | output | 1 | Wake/reset sequence active |

## Verification
The embedded assertions check the following on every cycle: the one-cycle stop and resume responses to the flags, the exclusivity of `sw_en` against `deep_lp` and `wake_rst`, the rule that `floor_sel` holds between strobes and never shows 2'b11, and the clearing of the dwell counter whenever the low flag drops. The bench's scenarios are needed to show the exact dwell length before deep entry, the restart of that dwell after a one-cycle gap in the low flag, the immunity of DEEP to the low flag, and the exact wake duration. These are compared against a behavioural model on every clock.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_HALT = 2'b01,
        ST_DEEP = 2'b10,
        ST_WAKE = 2'b11
    } bg_state_t;

    localparam logic [1:0] FLOOR_HIGH = 2'b00;
    localparam logic [1:0] FLOOR_MID  = 2'b01;
    localparam logic [1:0] FLOOR_LOW  = 2'b10;
endpackage

// File: rtl/entry_dwell_timer.sv
module entry_dwell_timer #(
    parameter int TICKS = 160000
) (
    input  logic clk,
    input  logic rst,
    input  logic lo_flag,
    output logic dwell_hit
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !lo_flag) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dwell_hit = lo_flag && (cnt == LAST);

    // R5: any cycle without the low flag restarts the dwell
    assert_dwell_restart_R5: assert property (@(posedge clk) disable iff (rst)
        !lo_flag |=> (cnt == '0));
endmodule

// File: rtl/wake_seq_timer.sv
module wake_seq_timer #(
    parameter int TICKS = 6250
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);

    // R6: the wake count never runs past its length
    assert_wake_bound_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= LAST));
endmodule

// File: rtl/floor_select.sv
module floor_select
    import burst_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       hi_flag,
    input  logic       blank_flag,
    output logic [1:0] sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= FLOOR_HIGH;
        end else if (strobe) begin
            if (!hi_flag) begin
                sel <= FLOOR_LOW;
            end else if (blank_flag) begin
                sel <= FLOOR_HIGH;
            end else begin
                sel <= FLOOR_MID;
            end
        end
    end

    // R9: no change without a cycle strobe
    assert_floor_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(sel));
    // R8: unused code never appears
    assert_floor_code_R8: assert property (@(posedge clk) disable iff (rst)
        sel != 2'b11);
    // R10: strobe with high flag clear selects low floor
    assert_floor_low_R10: assert property (@(posedge clk) disable iff (rst)
        (strobe && !hi_flag) |=> (sel == FLOOR_LOW));
endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
    import burst_gate_pkg::*;
#(
    parameter int ENTRY_TICKS = 160000,
    parameter int WAKE_TICKS  = 6250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fb_lo_flag,
    input  logic       fb_hi_flag,
    input  logic       fb_blank_flag,
    input  logic       cyc_strobe,
    output logic       sw_en,
    output logic       deep_lp,
    output logic [1:0] floor_sel,
    output logic       wake_rst
);
    initial begin
        if (ENTRY_TICKS < 2) $error("ENTRY_TICKS must be at least 2");
        if (WAKE_TICKS < 1)  $error("WAKE_TICKS must be at least 1");
    end

    bg_state_t state, state_nx;
    logic      dwell_hit;
    logic      wake_done;
    logic      in_wake;

    assign in_wake = (state == ST_WAKE);

    entry_dwell_timer #(.TICKS(ENTRY_TICKS)) u_dwell (
        .clk       (clk),
        .rst       (rst),
        .lo_flag   (fb_lo_flag),
        .dwell_hit (dwell_hit)
    );

    wake_seq_timer #(.TICKS(WAKE_TICKS)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .active (in_wake),
        .done   (wake_done)
    );

    floor_select u_floor (
        .clk        (clk),
        .rst        (rst),
        .strobe     (cyc_strobe),
        .hi_flag    (fb_hi_flag),
        .blank_flag (fb_blank_flag),
        .sel        (floor_sel)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (fb_lo_flag) state_nx = ST_HALT;
            ST_HALT: begin
                if (fb_hi_flag)     state_nx = ST_RUN;
                else if (dwell_hit) state_nx = ST_DEEP;
            end
            ST_DEEP: if (fb_hi_flag) state_nx = ST_WAKE;
            ST_WAKE: if (wake_done)  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    always_comb begin
        sw_en    = 1'b0;
        deep_lp  = 1'b0;
        wake_rst = 1'b0;
        unique case (state)
            ST_RUN:  sw_en    = 1'b1;
            ST_HALT: ;
            ST_DEEP: deep_lp  = 1'b1;
            ST_WAKE: wake_rst = 1'b1;
        endcase
    end

    // R2: low flag in run stops switching next cycle
    assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (sw_en && fb_lo_flag) |=> !sw_en);
    // R3: high flag in burst stop resumes switching next cycle
    assert_resume_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && fb_hi_flag) |=> sw_en);
    // R4: deep entry only from a stopped state with the low flag held
    assert_deep_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(deep_lp) |-> ($past(fb_lo_flag) && !$past(sw_en)));
    // R6: exit from deep goes through wake with switching off
    assert_wake_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (deep_lp && fb_hi_flag) |=> (wake_rst && !sw_en && !deep_lp));
    // R7: without the high flag, deep persists
    assert_deep_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (deep_lp && !fb_hi_flag) |=> deep_lp);
    // R11: exclusivity of outputs
    assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({sw_en, deep_lp, wake_rst}) <= 1);
endmodule

// File: tb/tb_burst_gate_ctrl.sv
module tb_burst_gate_ctrl;
    localparam int ENTRY = 20;
    localparam int WAKE  = 6;
    localparam int M_RUN = 0, M_HALT = 1, M_DEEP = 2, M_WAKE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lo = 1'b0, hi = 1'b0, blank = 1'b0, strobe = 1'b0;
    logic sw_en, deep_lp, wake_rst;
    logic [1:0] floor_sel;

    int checks = 0;
    int fails  = 0;

    int m_state = M_RUN;
    int m_run   = 0;
    int m_wake  = 0;
    int m_floor = 0;

    always #2 clk = ~clk;

    burst_gate_ctrl #(.ENTRY_TICKS(ENTRY), .WAKE_TICKS(WAKE)) dut (
        .clk(clk), .rst(rst), .fb_lo_flag(lo), .fb_hi_flag(hi),
        .fb_blank_flag(blank), .cyc_strobe(strobe), .sw_en(sw_en),
        .deep_lp(deep_lp), .floor_sel(floor_sel), .wake_rst(wake_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_state = M_RUN; m_run = 0; m_wake = 0; m_floor = 0;
        end else begin
            m_run = lo ? m_run + 1 : 0;
            case (m_state)
                M_RUN:  if (lo) m_state = M_HALT;
                M_HALT: if (hi) m_state = M_RUN;
                        else if (m_run >= ENTRY) m_state = M_DEEP;
                M_DEEP: if (hi) begin m_state = M_WAKE; m_wake = 0; end
                default: begin
                    m_wake++;
                    if (m_wake == WAKE) m_state = M_RUN;
                end
            endcase
            if (strobe) m_floor = !hi ? 2 : (blank ? 0 : 1);
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        check(sw_en == (m_state == M_RUN), "R2 R3 R6 sw_en", sw_en, m_state == M_RUN);
        check(deep_lp == (m_state == M_DEEP), "R4 R7 deep_lp", deep_lp, m_state == M_DEEP);
        check(wake_rst == (m_state == M_WAKE), "R6 wake_rst", wake_rst, m_state == M_WAKE);
        check(int'(floor_sel) == m_floor, "R8 R9 floor_sel", floor_sel, m_floor);
        check(!(sw_en && (deep_lp || wake_rst)), "R11 exclusive", sw_en, 0);
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int wcount;
        cyc(3);
        check(sw_en == 1 && deep_lp == 0 && wake_rst == 0 && floor_sel == 2'b00,
              "R1 reset state", {sw_en, deep_lp, wake_rst, floor_sel}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        check(sw_en == 1, "R1 after reset", sw_en, 1);

        // R2 stop, R3 hysteresis hold and resume
        lo = 1; @(negedge clk);
        check(sw_en == 0, "R2 stop on low flag", sw_en, 0);
        lo = 0; cyc(5);
        check(sw_en == 0, "R3 held in band", sw_en, 0);
        hi = 1; @(negedge clk);
        check(sw_en == 1, "R3 resume on high flag", sw_en, 1);
        hi = 0; cyc(2);

        // R5 dwell restart after one-cycle gap
        lo = 1; cyc(ENTRY - 2);
        lo = 0; @(negedge clk);
        lo = 1; cyc(ENTRY - 1);
        check(deep_lp == 0, "R5 dwell restarted", deep_lp, 0);
        // R4 entry at exactly ENTRY consecutive samples
        @(negedge clk);
        check(deep_lp == 1, "R4 deep entered", deep_lp, 1);

        // R7 low flag ignored in deep
        lo = 0; cyc(3); lo = 1; cyc(2); lo = 0; cyc(2);
        check(deep_lp == 1 && sw_en == 0, "R7 deep holds", deep_lp, 1);

        // R6 wake length
        hi = 1; @(negedge clk);
        hi = 0;
        check(deep_lp == 0 && wake_rst == 1, "R6 wake begins", wake_rst, 1);
        wcount = 0;
        while (wake_rst && wcount < 100) begin wcount++; @(negedge clk); end
        check(wcount == WAKE, "R6 wake duration", wcount, WAKE);
        check(sw_en == 1, "R6 switching after wake", sw_en, 1);

        // R8 R9 R10 floor selection
        hi = 1; blank = 0; strobe = 1; @(negedge clk); strobe = 0;
        check(floor_sel == 2'b01, "R8 middle floor", floor_sel, 1);
        blank = 1; cyc(3);
        check(floor_sel == 2'b01, "R9 no strobe no change", floor_sel, 1);
        strobe = 1; @(negedge clk); strobe = 0;
        check(floor_sel == 2'b00, "R8 high floor", floor_sel, 0);
        hi = 0; blank = 1; strobe = 1; @(negedge clk); strobe = 0;
        check(floor_sel == 2'b10, "R10 low floor with blank set", floor_sel, 2);
        hi = 1; blank = 0; cyc(2);
        check(floor_sel == 2'b10, "R9 hold low floor", floor_sel, 2);
        hi = 0; cyc(2);

        finish_run();
    end
endmodule